// File: doc/BRIEF.md
# CAN Standard Frame Serializer

The block takes one standard-format CAN frame descriptor (an 11-bit identifier, a remote-request flag, a length code and up to eight payload bytes) and sends it as an NRZ bit stream. It sends one bit for each pulse of an external bit-time tick. The 15-bit frame check is computed while the frame is being sent. Stuff bits are added where the rules require them. The acknowledge slot is driven recessive, and the receive line is sampled in that slot so the block can report whether any node acknowledged the frame.

The descriptor enters through a valid/ready handshake. The block is ready only while no frame is in progress. A descriptor is taken in the clock cycle where `req_valid` and `req_ready` are both high. The source must hold the descriptor stable while `req_valid` is high and `req_ready` is low. While a frame is in progress, nothing on the descriptor pins has any effect. If `req_valid` is held high across the end of a frame, the next descriptor is taken on the first cycle after `done`. The serial side has no handshake, because the bit clock sets its pace. `busy`, `done` and `ack_ok` are plain status pins.

Top module: `can_frame_tx`

## Requirements
- R1: `req_ready` equals the inverse of `busy`. A descriptor is taken when `req_valid && req_ready` at a clock edge, and `busy` is high from the next cycle. Descriptor pins and `req_valid` have no effect while `busy` is high.
- R2: `tx` is 1 (recessive) while idle and after reset. The first tick after a descriptor is taken sends the start bit as 0.
- R3: After the start bit, the header goes out in this order: the 11 identifier bits, the remote flag, two dominant (0) bits for the format flag and the reserved bit, then the 4-bit length code. Each field is sent MSB first.
- R4: The payload holds min(length code, 8) bytes, or no bytes when the remote flag is 1. Byte 0 is `req_data[63:56]` and goes first, and each byte is sent MSB first.
- R5: A 15-bit check follows the payload, MSB first. It is the remainder of polynomial 0x4599 (x^15+x^14+x^10+x^8+x^7+x^4+x^3+1), with the register starting at zero. It is computed over the unstuffed bits from the start bit to the last payload bit.
- R6: Stuffing applies from the start bit through the last check bit. After five equal bits in a row on `tx`, one complemented stuff bit is sent. The stuff bit counts as the first bit of the next run, and a stuff bit may follow the last check bit. No stuff bit is inserted anywhere after that.
- R7: After the check field, the block sends only recessive (1) bits: the check delimiter, the acknowledge slot, the acknowledge delimiter, 7 end-of-frame bits and 3 intermission bits.
- R8: `ack_ok` is cleared when a descriptor is taken. It is loaded with the inverse of `rx` on the tick that ends the acknowledge slot, which is the tick that sends the acknowledge delimiter. `rx` has no effect at any other time.
- R9: `done` is high for exactly one cycle, after the tick that sends the last intermission bit. `busy` falls in that same cycle.
- R10: `tx` changes only after a clock edge where `bit_tick` is high, and each such tick moves the stream by exactly one bit.
- R11: A length code above 8 is sent unchanged in the header, but only eight payload bytes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse for each bit time |
| req_valid | input | 1 | Descriptor valid |
| req_ready | output | 1 | Descriptor can be taken (block idle) |
| req_id | input | 11 | Frame identifier |
| req_rtr | input | 1 | Remote-request flag |
| req_dlc | input | 4 | Length code |
| req_data | input | 64 | Payload, byte 0 in bits 63:56 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| ack_ok | output | 1 | Acknowledge seen in the last frame |
| tx | output | 1 | Serial bit out |
| rx | input | 1 | Bus level, sampled in the acknowledge slot |

## Verification
The model is tried with several kinds of frame. An all-ones identifier with all-ones payload and an all-zeros frame produce the longest runs of equal bits, so they test stuff placement and the rule that a stuff bit starts a new run. Mixed payloads mainly test the check computation. Remote frames, zero-length frames and an oversized length code show which byte count the sequencer picks. `rx` is held low, held high or toggled at random to test that only the acknowledge slot is sampled. A back-to-back pair with `req_valid` held high, and a frame whose inputs are changed while busy, show that the handshake ignores everything during a frame. Tick spacings of one to four clocks test that output moves only on ticks.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  typedef enum logic [3:0] {
    FLD_IDLE, FLD_HDR, FLD_DATA, FLD_CRC, FLD_CRC_DELIM,
    FLD_ACK, FLD_ACK_DELIM, FLD_EOF, FLD_IFS
  } fld_e;
  localparam int DEF_ID_W      = 11;
  localparam int DEF_DLC_W     = 4;
  localparam int DEF_MAX_BYTES = 8;
  localparam int DEF_CRC_W     = 15;
  localparam logic [14:0] DEF_CRC_POLY = 15'h4599;
  localparam int DEF_STUFF_RUN = 5;
  localparam int DEF_EOF_LEN   = 7;
  localparam int DEF_IFS_LEN   = 3;
endpackage

// File: rtl/can_crc15.sv
module can_crc15 #(
  parameter int CRC_W = 15,
  parameter logic [CRC_W-1:0] POLY = 15'h4599
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic update,
  input  logic shift_out,
  input  logic bit_in,
  output logic msb
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb  = bit_in ^ crc_q[CRC_W-1];
  assign msb = crc_q[CRC_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)          crc_q <= '0;
    else if (clear)      crc_q <= '0;
    else if (update)     crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    else if (shift_out)  crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end

  // the check register starts every frame from zero (R5)
  p_crc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_q == '0));
  p_crc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear || update || shift_out) |=> $stable(crc_q));
endmodule

// File: rtl/can_stuff_ctl.sv
module can_stuff_ctl #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic emit,
  input  logic stuffable,
  input  logic raw_bit,
  output logic stuff_due,
  output logic stuff_bit
);
  localparam int RCW = $clog2(RUN + 1);
  logic [RCW-1:0] run_cnt;
  logic           run_val;

  assign stuff_due = (run_cnt == RCW'(RUN));
  assign stuff_bit = ~run_val;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      run_cnt <= '0;
      run_val <= 1'b1;
    end else if (emit) begin
      if (stuff_due) begin
        run_val <= ~run_val;
        run_cnt <= RCW'(1);
      end else if (stuffable) begin
        if (run_cnt != '0 && raw_bit == run_val) run_cnt <= run_cnt + RCW'(1);
        else begin
          run_cnt <= RCW'(1);
          run_val <= raw_bit;
        end
      end else begin
        run_cnt <= '0;
      end
    end
  end

  p_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RCW'(RUN));
  p_run_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && stuff_due) |=> (run_cnt == RCW'(1)));
endmodule

// File: rtl/can_field_seq.sv
module can_field_seq
  import can_tx_pkg::*;
#(
  parameter int ID_W      = 11,
  parameter int DLC_W     = 4,
  parameter int MAX_BYTES = 8,
  parameter int CRC_W     = 15,
  parameter int EOF_LEN   = 7,
  parameter int IFS_LEN   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [ID_W-1:0]        id,
  input  logic                   rtr,
  input  logic [DLC_W-1:0]       dlc,
  input  logic [MAX_BYTES*8-1:0] data,
  input  logic                   adv,
  input  logic                   crc_msb,
  output fld_e                   fld,
  output logic                   bit_o,
  output logic                   stuffable,
  output logic                   crc_cover,
  output logic                   last_bit,
  output logic                   busy
);
  localparam int HDR_W  = 1 + ID_W + 1 + 2 + DLC_W;
  localparam int DATA_W = MAX_BYTES * 8;
  localparam int CNT_W  = $clog2(HDR_W + DATA_W + CRC_W + EOF_LEN + IFS_LEN + 1);

  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt, nbits, nbits_d, nxt_cnt;
  fld_e              nxt_fld;

  always_comb begin
    if (rtr)                      nbits_d = '0;
    else if (int'(dlc) > MAX_BYTES) nbits_d = CNT_W'(DATA_W);
    else                          nbits_d = CNT_W'(dlc) << 3;
  end

  always_comb begin
    nxt_fld = FLD_IDLE;
    nxt_cnt = '0;
    case (fld)
      FLD_HDR: if (nbits == '0) begin
                 nxt_fld = FLD_CRC;  nxt_cnt = CNT_W'(CRC_W - 1);
               end else begin
                 nxt_fld = FLD_DATA; nxt_cnt = nbits - CNT_W'(1);
               end
      FLD_DATA:      begin nxt_fld = FLD_CRC;       nxt_cnt = CNT_W'(CRC_W - 1);   end
      FLD_CRC:       nxt_fld = FLD_CRC_DELIM;
      FLD_CRC_DELIM: nxt_fld = FLD_ACK;
      FLD_ACK:       nxt_fld = FLD_ACK_DELIM;
      FLD_ACK_DELIM: begin nxt_fld = FLD_EOF;       nxt_cnt = CNT_W'(EOF_LEN - 1); end
      FLD_EOF:       begin nxt_fld = FLD_IFS;       nxt_cnt = CNT_W'(IFS_LEN - 1); end
      default:       nxt_fld = FLD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld    <= FLD_IDLE;
      cnt    <= '0;
      hdr_q  <= '0;
      data_q <= '0;
      nbits  <= '0;
    end else if (load) begin
      fld    <= FLD_HDR;
      cnt    <= CNT_W'(HDR_W - 1);
      hdr_q  <= {1'b0, id, rtr, 2'b00, dlc};
      data_q <= data;
      nbits  <= nbits_d;
    end else if (adv) begin
      if (fld == FLD_HDR)  hdr_q  <= hdr_q << 1;
      if (fld == FLD_DATA) data_q <= data_q << 1;
      if (cnt != '0) cnt <= cnt - CNT_W'(1);
      else begin
        fld <= nxt_fld;
        cnt <= nxt_cnt;
      end
    end
  end

  always_comb begin
    case (fld)
      FLD_HDR:  bit_o = hdr_q[HDR_W-1];
      FLD_DATA: bit_o = data_q[DATA_W-1];
      FLD_CRC:  bit_o = crc_msb;
      default:  bit_o = 1'b1;
    endcase
  end

  assign stuffable = (fld == FLD_HDR) || (fld == FLD_DATA) || (fld == FLD_CRC);
  assign crc_cover = (fld == FLD_HDR) || (fld == FLD_DATA);
  assign last_bit  = (fld == FLD_IFS) && (cnt == '0);
  assign busy      = (fld != FLD_IDLE);

  // payload counter never exceeds the chosen byte count (R4, R11)
  p_data_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fld == FLD_DATA) |-> (cnt < nbits));
  p_load_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (fld == FLD_IDLE));
endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx
  import can_tx_pkg::*;
#(
  parameter int ID_W      = DEF_ID_W,
  parameter int DLC_W     = DEF_DLC_W,
  parameter int MAX_BYTES = DEF_MAX_BYTES,
  parameter int CRC_W     = DEF_CRC_W,
  parameter logic [CRC_W-1:0] CRC_POLY = DEF_CRC_POLY,
  parameter int STUFF_RUN = DEF_STUFF_RUN,
  parameter int EOF_LEN   = DEF_EOF_LEN,
  parameter int IFS_LEN   = DEF_IFS_LEN
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_tick,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ID_W-1:0]        req_id,
  input  logic                   req_rtr,
  input  logic [DLC_W-1:0]       req_dlc,
  input  logic [MAX_BYTES*8-1:0] req_data,
  output logic                   busy,
  output logic                   done,
  output logic                   ack_ok,
  output logic                   tx,
  input  logic                   rx
);
  fld_e fld;
  logic accept, emit, adv;
  logic raw_bit, stuffable, crc_cover, last_bit, crc_msb;
  logic stuff_due, stuff_bit;

  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;
  assign emit      = bit_tick & busy;
  assign adv       = emit & ~stuff_due;

  can_field_seq #(
    .ID_W(ID_W), .DLC_W(DLC_W), .MAX_BYTES(MAX_BYTES),
    .CRC_W(CRC_W), .EOF_LEN(EOF_LEN), .IFS_LEN(IFS_LEN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .id(req_id), .rtr(req_rtr), .dlc(req_dlc), .data(req_data),
    .adv(adv), .crc_msb(crc_msb), .fld(fld), .bit_o(raw_bit),
    .stuffable(stuffable), .crc_cover(crc_cover),
    .last_bit(last_bit), .busy(busy)
  );

  can_crc15 #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .update(adv & crc_cover), .shift_out(adv & (fld == FLD_CRC)),
    .bit_in(raw_bit), .msb(crc_msb)
  );

  can_stuff_ctl #(.RUN(STUFF_RUN)) u_stuff (
    .clk(clk), .rst_n(rst_n), .clear(accept), .emit(emit),
    .stuffable(stuffable), .raw_bit(raw_bit),
    .stuff_due(stuff_due), .stuff_bit(stuff_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx     <= 1'b1;
      done   <= 1'b0;
      ack_ok <= 1'b0;
    end else begin
      done <= adv & last_bit;
      if (emit) tx <= stuff_due ? stuff_bit : raw_bit;
      if (accept) ack_ok <= 1'b0;
      else if (adv && fld == FLD_ACK_DELIM) ack_ok <= ~rx;
    end
  end

  p_idle_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);
  p_tick_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx));
  p_stuff_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && stuff_due) |=> (tx != $past(tx)));
  p_trailer_recessive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !stuffable && fld != FLD_IDLE) |=> tx);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ack_ok);
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
endmodule

// File: tb/sim_can_frame_tx.sv
module sim_can_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [10:0] req_id = '0;
  logic        req_rtr = 1'b0;
  logic [3:0]  req_dlc = '0;
  logic [63:0] req_data = '0;
  logic        busy, done, ack_ok, tx;
  logic        rx = 1'b1;

  int checks = 0;
  int errors = 0;
  int tick_period = 3;
  int tick_div = 0;
  int rx_mode = 1;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  can_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .req_valid(req_valid),
    .req_ready(req_ready), .req_id(req_id), .req_rtr(req_rtr),
    .req_dlc(req_dlc), .req_data(req_data), .busy(busy), .done(done),
    .ack_ok(ack_ok), .tx(tx), .rx(rx)
  );

  // reference model state
  bit    q_bits[$];
  string q_tags[$];
  bit    m_tx = 1, m_busy = 0, m_done = 0, m_ack = 0;
  string m_tag = "R2";

  function automatic void build(input logic [10:0] id, input bit rtr,
                                input logic [3:0] dlc, input logic [63:0] data);
    bit    raw[$];
    string rtag[$];
    logic [14:0] crc = '0;
    int nbytes;
    int run = 0;
    bit last = 1;
    q_bits.delete();
    q_tags.delete();
    raw.push_back(0); rtag.push_back("R2");
    for (int i = 10; i >= 0; i--) begin raw.push_back(id[i]); rtag.push_back("R3"); end
    raw.push_back(rtr); rtag.push_back("R3");
    raw.push_back(0); rtag.push_back("R3");
    raw.push_back(0); rtag.push_back("R3");
    for (int i = 3; i >= 0; i--) begin
      raw.push_back(dlc[i]); rtag.push_back(dlc > 8 ? "R11" : "R3");
    end
    nbytes = rtr ? 0 : (dlc > 8 ? 8 : int'(dlc));
    for (int i = 0; i < nbytes * 8; i++) begin
      raw.push_back(data[63 - i]); rtag.push_back(dlc > 8 ? "R11" : "R4");
    end
    foreach (raw[i]) begin
      bit fb;
      fb  = raw[i] ^ crc[14];
      crc = {crc[13:0], 1'b0};
      if (fb) crc = crc ^ 15'h4599;
    end
    for (int i = 14; i >= 0; i--) begin raw.push_back(crc[i]); rtag.push_back("R5"); end
    foreach (raw[i]) begin
      q_bits.push_back(raw[i]); q_tags.push_back(rtag[i]);
      if (run != 0 && raw[i] == last) run++;
      else begin run = 1; last = raw[i]; end
      if (run == 5) begin
        q_bits.push_back(~last); q_tags.push_back("R6");
        last = ~last; run = 1;
      end
    end
    for (int i = 0; i < 13; i++) begin q_bits.push_back(1); q_tags.push_back("R7"); end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tx <= 1; m_busy <= 0; m_done <= 0; m_ack <= 0; m_tag = "R2";
    end else begin
      m_done <= 0;
      if (!m_busy && req_valid) begin
        build(req_id, req_rtr, req_dlc, req_data);
        m_busy <= 1;
        m_ack  <= 0;
      end else if (m_busy && bit_tick) begin
        if (q_bits.size() == 11) m_ack <= ~rx;
        if (q_bits.size() == 1) begin m_busy <= 0; m_done <= 1; end
        m_tx  <= q_bits.pop_front();
        m_tag = q_tags.pop_front();
      end
    end
  end

  always @(negedge clk) begin
    if (tick_div >= tick_period - 1) begin bit_tick <= 1; tick_div <= 0; end
    else begin bit_tick <= 0; tick_div <= tick_div + 1; end
    rx <= (rx_mode == 2) ? 1'($urandom % 2) : 1'(rx_mode);
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(tx == m_tx, {m_tag, " R10"}, "tx", tx, m_tx);
      chk(busy == m_busy && req_ready == !m_busy, "R1", "busy", busy, m_busy);
      chk(done == m_done, "R9", "done", done, m_done);
      chk(ack_ok == m_ack, "R8", "ack_ok", ack_ok, m_ack);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(input logic [10:0] id, input bit rtr, input logic [3:0] dlc,
                      input logic [63:0] data, input int rxm, input bit keep);
    req_id = id; req_rtr = rtr; req_dlc = dlc; req_data = data; req_valid = 1;
    rx_mode = rxm;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (!keep) req_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy || m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R1, R2, R8, R9)
    chk(tx == 1, "R2", "reset tx", tx, 1);
    chk(req_ready == 1 && busy == 0, "R1", "reset ready", req_ready, 1);
    chk(done == 0, "R9", "reset done", done, 0);
    chk(ack_ok == 0, "R8", "reset ack", ack_ok, 0);

    tick_period = 3;
    send(11'h123, 0, 4'd2, 64'hA55A_0000_0000_0000, 0, 0); wait_idle();
    chk(ack_ok == 1, "R8", "ack held low", ack_ok, 1);
    send(11'h7FF, 0, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0); wait_idle();
    chk(ack_ok == 0, "R8", "ack held high", ack_ok, 0);
    tick_period = 1;
    send(11'h000, 0, 4'd8, 64'h0, 2, 0); wait_idle();
    tick_period = 4;
    send(11'h2A5, 1, 4'd5, 64'h1234_5678_9ABC_DEF0, 0, 0); wait_idle();  // R4 remote
    send(11'h05F, 0, 4'd0, 64'hFFFF_0000_FFFF_0000, 2, 0); wait_idle();
    tick_period = 2;
    send(11'h3C3, 0, 4'd15, 64'h0F0F_F0F0_3C3C_C3C3, 0, 0); wait_idle();  // R11
    // back-to-back with valid held; second descriptor set while busy (R1)
    send(11'h111, 0, 4'd3, 64'hDEAD_BEEF_0000_0000, 0, 1);
    send(11'h6E1, 0, 4'd1, 64'h8000_0000_0000_0000, 2, 0); wait_idle();
    // inputs scribbled and valid pulsed mid-frame must be ignored (R1)
    tick_period = 3;
    send(11'h400, 0, 4'd4, 64'h0102_0304_0000_0000, 0, 0);
    repeat (40) @(negedge clk);
    req_id = 11'h7AA; req_dlc = 4'd7; req_data = '1; req_valid = 1;
    @(negedge clk); req_valid = 0;
    wait_idle();
    for (int k = 0; k < 6; k++) begin
      tick_period = 1 + (k % 4);
      send(11'($urandom), 1'($urandom % 4 == 0), 4'($urandom), {$urandom, $urandom},
           k % 3, 0);
      wait_idle();
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule